// File: doc/BRIEF.md
# Video-Clocked Memory Streamer

This block sends the contents of a 128-byte memory over and over onto a shared open-drain data line. A slow video-rate clock, fed in from outside and sampled on the system clock, paces the output. Each detected rising edge of that clock moves the line to its next bit. A byte takes nine edges: eight data bits, most significant first, then one released null bit. The address runs upward and wraps back to zero, so the stream never ends.

After reset the block stays silent for a warm-up period of nine edges, and only the tenth edge drives the first data bit. A separate mode controller gives the block an enable, which stays high while the serial bus clock is idle-high. When the enable drops, the line is released and the byte and bit position go back to the start. When the enable returns, streaming starts again from the top bit of address zero, and there is no second warm-up.

The block reads the memory through a plain asynchronous read port: it drives an address and expects the data in the same cycle. On the line it only ever pulls low. A one bit and the null bit both leave the line released.

Top module: `vclk_byte_streamer`

## Requirements
- R1: While reset is high and in the cycle after it, `sda_oe` is 0 and `rd_addr` is 0.
- R2: After reset, the first nine video-clock rising edges seen while `stream_en` is 1 are warm-up edges. `sda_oe` stays 0 throughout and `rd_addr` stays 0. Edges seen while `stream_en` is 0 are not counted.
- R3: The tenth counted edge drives the top bit (bit 7) of the byte at address 0. The level of `vclk_in` is first sampled high at one system-clock edge, and `sda_oe` takes the new value at the second system-clock edge after that one.
- R4: `sda_oe` is 1 (line pulled low) for a data bit of 0, and 0 (line released) for a data bit of 1. The eight data bits of each byte go out from bit 7 down to bit 0, one per edge.
- R5: The ninth edge of each byte produces a null bit with `sda_oe` at 0.
- R6: Bytes are sent from addresses 0, 1, … 127 in order, then 0 again, without end. `rd_addr` holds the next address to be read. The byte is taken from `rd_data` in the same cycle as the edge that sends its top bit, and `rd_addr` then steps by one.
- R7: In the cycle after any cycle with `stream_en` at 0, `sda_oe` is 0. Video-clock edges that arrive while `stream_en` is 0 leave `sda_oe` at 0 and `rd_addr` at 0.
- R8: When `stream_en` returns to 1 after warm-up has finished, the next edge drives bit 7 of address 0. Warm-up is not repeated.
- R9: While `stream_en` is 1, `sda_oe` changes only at the system-clock edge that acts on a detected video-clock rising edge. Holding the video clock at either level leaves `sda_oe` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vclk_in | input | 1 | Video-rate clock, asynchronous to `clk` |
| stream_en | input | 1 | Streaming allowed (from the mode controller) |
| rd_addr | output | 7 | Memory read address |
| rd_data | input | 8 | Memory read data for `rd_addr`, valid in the same cycle |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The assertions assume that every pulse of `vclk_in`, high and low, lasts long enough for the two-flop synchronizer to see it. They also assume that `rd_data` always follows `rd_addr` within the same cycle. The stimulus holds each level of `vclk_in` for three system clocks and changes `stream_en` and `rst` only one nanosecond after an edge. The memory model is a combinational function of the address. Under those conditions, a per-cycle behavioural model of the stream must match `sda_oe` exactly, including the cycles around enable drops and a second reset.

// File: rtl/vstream_pkg.sv
package vstream_pkg;

    localparam int DEF_ADDR_W      = 7;
    localparam int DEF_DATA_W      = 8;
    localparam int DEF_INIT_EDGES  = 9;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [0:0] {
        PH_WARMUP = 1'b0,
        PH_STREAM = 1'b1
    } phase_t;

    // Open-drain rule: only a zero bit pulls the line.
    function automatic logic bit_to_pull(input logic line_bit);
        return ~line_bit;
    endfunction

endpackage

// File: rtl/vstream_edge_sync.sv
module vstream_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int CHAIN_W = STAGES + 1;

    // Bits [STAGES-1:0] form the synchronizer, bit STAGES is the history flop.
    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_W-2:0], async_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/vstream_warmup.sv
module vstream_warmup
    import vstream_pkg::*;
#(
    parameter int INIT_EDGES = DEF_INIT_EDGES
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic rise,
    output logic ready
);
    localparam int CNT_W = $clog2(INIT_EDGES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(INIT_EDGES - 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_WARMUP;
            cnt   <= '0;
        end else if (phase == PH_WARMUP && enable && rise) begin
            if (cnt == LAST_CNT) begin
                phase <= PH_STREAM;
            end
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = (phase == PH_STREAM);

endmodule

// File: rtl/vstream_slot_seq.sv
module vstream_slot_seq
    import vstream_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        enable,
    input  logic                        step,
    input  logic [DATA_W-1:0]           rd_data,
    output logic [ADDR_W-1:0]           rd_addr,
    output logic [$clog2(DATA_W+1)-1:0] pos_o,
    output logic                        pull_next
);
    localparam int SLOTS = DATA_W + 1;
    localparam int POS_W = $clog2(SLOTS);
    localparam logic [POS_W-1:0] NULL_POS = POS_W'(DATA_W);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [POS_W-1:0]  pos;
        logic [DATA_W-1:0] shreg;
    } slot_t;

    slot_t cur;
    slot_t nxt;
    logic  line_bit;

    always_comb begin
        nxt = cur;
        if (!enable) begin
            nxt = '0;
        end else if (step) begin
            if (cur.pos == '0) begin
                nxt.shreg = rd_data << 1;
                nxt.addr  = cur.addr + 1'b1;
                nxt.pos   = POS_W'(1);
            end else if (cur.pos == NULL_POS) begin
                nxt.pos = '0;
            end else begin
                nxt.shreg = cur.shreg << 1;
                nxt.pos   = cur.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    always_comb begin
        if (cur.pos == '0) begin
            line_bit = rd_data[DATA_W-1];
        end else if (cur.pos == NULL_POS) begin
            line_bit = 1'b1;
        end else begin
            line_bit = cur.shreg[DATA_W-1];
        end
    end

    assign pull_next = bit_to_pull(line_bit);
    assign rd_addr   = cur.addr;
    assign pos_o     = cur.pos;

endmodule

// File: rtl/vstream_od_drive.sv
module vstream_od_drive (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic load,
    input  logic pull_next,
    output logic sda_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sda_oe <= 1'b0;
        end else if (!enable) begin
            sda_oe <= 1'b0;
        end else if (load) begin
            sda_oe <= pull_next;
        end
    end

endmodule

// File: rtl/vclk_byte_streamer.sv
module vclk_byte_streamer
    import vstream_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int DATA_W      = DEF_DATA_W,
    parameter int INIT_EDGES  = DEF_INIT_EDGES,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vclk_in,
    input  logic              stream_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe
);
    localparam int POS_W = $clog2(DATA_W + 1);

    logic             vclk_rise;
    logic             stream_ready;
    logic             slot_step;
    logic             pull_next;
    logic [POS_W-1:0] slot_pos;

    vstream_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (vclk_in),
        .rise     (vclk_rise)
    );

    vstream_warmup #(
        .INIT_EDGES (INIT_EDGES)
    ) u_warm (
        .clk    (clk),
        .rst    (rst),
        .enable (stream_en),
        .rise   (vclk_rise),
        .ready  (stream_ready)
    );

    assign slot_step = vclk_rise & stream_en & stream_ready;

    vstream_slot_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (stream_en),
        .step      (slot_step),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .pos_o     (slot_pos),
        .pull_next (pull_next)
    );

    vstream_od_drive u_drv (
        .clk       (clk),
        .rst       (rst),
        .enable    (stream_en),
        .load      (slot_step),
        .pull_next (pull_next),
        .sda_oe    (sda_oe)
    );

endmodule

// File: rtl/vstream_checker.sv
module vstream_checker #(
    parameter int ADDR_W   = 7,
    parameter int POS_W    = 4,
    parameter int NULL_POS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              stream_en,
    input logic              vclk_rise,
    input logic              ready,
    input logic [POS_W-1:0]  pos,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              sda_oe
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!sda_oe && rd_addr == '0));

    assert_quiet_warmup_R2: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !sda_oe);

    assert_single_rise_R3: assert property (@(posedge clk) disable iff (rst)
        vclk_rise |=> !vclk_rise);

    assert_null_released_R5: assert property (@(posedge clk) disable iff (rst)
        (stream_en && vclk_rise && ready && pos == POS_W'(NULL_POS)) |=> !sda_oe);

    assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (stream_en && vclk_rise && ready && pos == '0) |=> (rd_addr == $past(rd_addr) + 1'b1));

    assert_release_when_off_R7: assert property (@(posedge clk) disable iff (rst)
        !stream_en |=> !sda_oe);

    assert_restart_origin_R8: assert property (@(posedge clk) disable iff (rst)
        !stream_en |=> (rd_addr == '0 && pos == '0));

    assert_hold_between_edges_R9: assert property (@(posedge clk) disable iff (rst)
        (stream_en && !vclk_rise) |=> $stable(sda_oe));

endmodule

bind vclk_byte_streamer vstream_checker #(
    .ADDR_W   (ADDR_W),
    .POS_W    (POS_W),
    .NULL_POS (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stream_en (stream_en),
    .vclk_rise (vclk_rise),
    .ready     (stream_ready),
    .pos       (slot_pos),
    .rd_addr   (rd_addr),
    .sda_oe    (sda_oe)
);

// File: tb/sim_vclk_byte_streamer.sv
`timescale 1ns/100ps
module sim_vclk_byte_streamer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vclk_in = 1'b0;
    logic       stream_en = 1'b1;
    logic [6:0] rd_addr;
    logic [7:0] rd_data;
    logic       sda_oe;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 29 + 75) % 256);
    endfunction

    assign rd_data = mem_byte(int'(rd_addr));

    vclk_byte_streamer u0 (
        .clk       (clk),
        .rst       (rst),
        .vclk_in   (vclk_in),
        .stream_en (stream_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe)
    );

    // Behavioural reference model of the stream.
    bit hist[$] = '{0, 0, 0};
    int warm = 0;
    int idx  = 0;
    int slot = 0;
    bit exp_oe = 0;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{0, 0, 0};
            warm = 0; idx = 0; slot = 0; exp_oe = 0;
        end else begin
            bit seen_rise;
            seen_rise = hist[1] && !hist[2];
            if (!stream_en) begin
                exp_oe = 0; idx = 0; slot = 0;
            end else if (seen_rise) begin
                if (warm < 9) begin
                    warm++;
                end else begin
                    exp_oe = (slot < 8) ? !mem_byte(idx)[7 - slot] : 1'b0;
                    slot++;
                    if (slot == 9) begin
                        slot = 0;
                        idx  = (idx + 1) % 128;
                    end
                end
            end
            hist.push_front(vclk_in);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_tests++;
            if (sda_oe !== exp_oe) begin
                n_fail++;
                $display("FAIL R4 per-cycle model at %0t: sda_oe=%0b expected=%0b", $time, sda_oe, exp_oe);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse();
        vclk_in = 1'b1;
        tick(3);
        vclk_in = 1'b0;
        tick(3);
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(4);
        check("R1 sda_oe in reset", int'(sda_oe), 0);
        check("R1 rd_addr in reset", int'(rd_addr), 0);
        rst = 1'b0;
        tick(1);
        check("R1 sda_oe after reset", int'(sda_oe), 0);

        // R2: nine warm-up edges, plus one ignored while disabled
        stream_en = 1'b0;
        pulse();
        stream_en = 1'b1;
        tick(1);
        for (int i = 0; i < 9; i++) pulse();
        check("R2 line quiet after warm-up", int'(sda_oe), 0);
        check("R2 address held in warm-up", int'(rd_addr), 0);

        // R3: tenth edge, exact latency
        vclk_in = 1'b1;
        tick(2);
        check("R3 not yet updated", int'(sda_oe), 0);
        tick(1);
        check("R3 first bit of address 0", int'(sda_oe), int'(!mem_byte(0)[7]));
        check("R6 address stepped on load", int'(rd_addr), 1);
        vclk_in = 1'b0;
        tick(3);

        for (int b = 6; b >= 0; b--) begin
            pulse();
            check("R4 data bit of byte 0", int'(sda_oe), int'(!mem_byte(0)[b]));
        end
        pulse();
        check("R5 null bit released", int'(sda_oe), 0);

        for (int k = 0; k < 127 * 9; k++) pulse();
        check("R6 address wrapped", int'(rd_addr), 0);
        pulse();
        check("R6 wrap resends byte 0", int'(sda_oe), int'(!mem_byte(0)[7]));

        // R7: drop enable while pulling low
        stream_en = 1'b0;
        tick(1);
        check("R7 released after disable", int'(sda_oe), 0);
        for (int k = 0; k < 4; k++) pulse();
        check("R7 edges ignored: line", int'(sda_oe), 0);
        check("R7 edges ignored: address", int'(rd_addr), 0);

        // R8: restart without warm-up
        stream_en = 1'b1;
        tick(1);
        pulse();
        check("R8 restart at bit 7 of address 0", int'(sda_oe), int'(!mem_byte(0)[7]));
        pulse();
        check("R8 second bit after restart", int'(sda_oe), int'(!mem_byte(0)[6]));
        pulse();
        check("R9 bit 5 of byte 0", int'(sda_oe), int'(!mem_byte(0)[5]));

        // R9: long holds at both levels
        vclk_in = 1'b1;
        tick(12);
        check("R9 hold during long high", int'(sda_oe), int'(!mem_byte(0)[4]));
        vclk_in = 1'b0;
        tick(12);
        check("R9 hold during long low", int'(sda_oe), int'(!mem_byte(0)[4]));

        // Second reset re-arms warm-up
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        check("R1 line after second reset", int'(sda_oe), 0);
        pulse();
        check("R2 warm-up after second reset", int'(sda_oe), 0);
        for (int i = 0; i < 8; i++) pulse();
        pulse();
        check("R3 first bit after second warm-up", int'(sda_oe), int'(!mem_byte(0)[7]));

        tick(4);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule